// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. It watches oversampled copies of the bus clock and data lines and pulls the data line low through a single enable output. Frame boundaries are found from data transitions while the clock is high. It decodes a select byte, a word address, and data bytes that arrive after the address. It answers with acknowledge bits and returns read data one bit per clock. The storage is an internal byte array with a synchronous read port, so it can be mapped to block RAM.

Writes collect into a 16-byte page buffer. A STOP that closes a write frame starts a programming cycle, and a counter stands in for the cell programming time. During that cycle the slave does not respond on the bus. Once the counter expires, the buffered bytes are copied into the array. Reads can be random (write select, address, repeated START, read select) or current-address (read select only). They continue byte after byte while the master acknowledges. The density parameter ranges from 128 to 2048 bytes and decides how many chip-enable strap bits are replaced by high address bits in the select byte.

Top module: `twowire_mem_slave`

## Requirements
- R1: A select byte is acknowledged only when its bits 7..4 are 1010 and each of its bits 3..1 that is not used for addressing equals the strap `chip_sel_i[2..0]` in the same order. A select byte that does not match gets no acknowledge, and the slave ignores the bus until the next START.
- R2: With MEM_BYTES = 512, select bit 1 carries address bit 8 and strap bit 0 is ignored. With 1024, bits 2..1 carry address bits 9..8. With 2048, bits 3..1 carry address bits 10..8. In a write-mode select these bits form the high part of the word address.
- R3: START is data falling while the clock is high, and STOP is data rising while the clock is high. Bits are taken on clock rising edges, most significant bit first. The slave acknowledges by pulling data low during the ninth clock, and it changes its pull only while the clock is low.
- R4: After the address byte, each data byte is acknowledged and placed at the current address. The low 4 address bits then advance and wrap inside the 16-byte page while the upper bits stay fixed, so a 17th byte replaces the first.
- R5: When `wr_lock_i` is 1, the select and address bytes are still acknowledged, every data byte gets no acknowledge, and nothing is stored.
- R6: A STOP on a byte boundary after at least one accepted data byte starts a programming cycle of BUSY_CYCLES + 16 clocks. During the cycle the slave ignores START and acknowledges nothing. The buffered bytes reach the array at the end of the cycle.
- R7: A START at any point in a write frame, or a STOP after 2 to 8 bits of a byte, discards the buffered data. No programming cycle follows.
- R8: A random read returns the byte at the address sent in the preceding write-mode frame.
- R9: While the master acknowledges, reads continue at the next address, wrapping from the last array address to 0. The address is kept between frames, so a current-address read starts one past the last byte read.
- R10: After a master no-acknowledge, the slave stops driving data and stays released until a new START.
- R11: After reset the data pull is released, and the slave does not respond until a START is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| chip_sel_i | input | 3 | Chip-enable straps compared with select bits 3..1 |
| wr_lock_i | input | 1 | 1 blocks storage of data bytes |

## Verification
The hardest case to reach is a frame that ends in a way that must not program anything. Examples are a STOP several bits into a data byte, and a repeated START followed by a read after data has already been acknowledged. The bench produces these by sending partial bytes bit by bit and then issuing the boundary condition. It then runs a random read at once, with no wait. The slave must acknowledge that read, which proves no programming cycle started, and the read must return the old contents. The busy window is reached by issuing a new START right after a committing STOP, before the counter can expire.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } smem_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_COMMIT
  } prog_phase_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Strap bits still compared once hi address bits take over the low ones
  function automatic logic [2:0] ce_mask(input int hi_bits);
    return 3'b111 << hi_bits;
  endfunction

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_o <= cells[raddr_i];
  end

endmodule

// File: rtl/smem_page_buf.sv
module smem_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic          any_o
);

  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      filled <= '0;
    end else if (wr_i) begin
      filled[wr_idx_i] <= 1'b1;
    end
    if (wr_i) slot[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o  = slot[rd_idx_i];
  assign rd_valid_o = filled[rd_idx_i];
  assign any_o      = |filled;

  // Clearing and filling come from disjoint bus events
  AST_PAGE_CLR_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(clr_i && wr_i)); // R7

endmodule

// File: rtl/smem_prog_timer.sv
module smem_prog_timer
  import smem_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000,
  parameter int PAGE_BYTES  = 16,
  localparam int CW = $clog2(BUSY_CYCLES + 1),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [PW-1:0] idx_o,
  output logic          done_o
);

  prog_phase_e   phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx_o <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start_i) begin
          phase <= PH_WAIT;
          cnt   <= '0;
        end
        PH_WAIT: if (cnt == CW'(BUSY_CYCLES - 1)) begin
          phase <= PH_COMMIT;
          idx_o <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_COMMIT: if (idx_o == PW'(PAGE_BYTES - 1)) phase <= PH_IDLE;
                   else idx_o <= idx_o + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (phase != PH_IDLE);
  assign commit_o = (phase == PH_COMMIT);
  assign done_o   = commit_o && (idx_o == PW'(PAGE_BYTES - 1));

  AST_PROG_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (phase == PH_IDLE)); // R6

endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import smem_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] chip_sel_i,
  input  logic       wr_lock_i
);

  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int HI  = (AW > 8) ? AW - 8 : 0;
  localparam int HIW = (HI > 0) ? HI : 1;
  localparam logic [2:0] CE_MASK = ce_mask(HI);

  // Bus line conditioning
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  // Frame state
  smem_state_e    state;
  logic [3:0]     bit_cnt;
  logic           in_ack;
  logic           mack;
  logic [7:0]     rx_byte;
  logic [6:0]     tx_rest;
  logic [AW-1:0]  ptr;
  logic [HIW-1:0] sel_hi_q, sel_hi_field;
  logic [AW-1:0]  addr_cat;
  logic           pull_q;

  // Programming path
  logic           prog_busy, prog_commit, prog_done, prog_start;
  logic [PW-1:0]  commit_idx;
  logic           buf_wr, buf_clr, buf_rvalid, buf_any;
  logic [7:0]     buf_rdata, rd_q;
  logic           arr_we;

  generate
    if (HI > 0) begin : g_hi_addr
      assign sel_hi_field = rx_byte[HI:1];
      assign addr_cat     = {sel_hi_q, rx_byte};
    end else begin : g_flat_addr
      assign sel_hi_field = 1'b0;
      assign addr_cat     = rx_byte[AW-1:0];
    end
  endgenerate

  logic sel_ok, byte_done, ack_end, commit_ok;

  always_comb begin
    sel_ok    = (rx_byte[7:4] == DEV_TYPE) &&
                (((rx_byte[3:1] ^ chip_sel_i) & CE_MASK) == 3'b000);
    byte_done = scl_fall && (bit_cnt == 4'd8) && !in_ack && !prog_busy &&
                (state != ST_IDLE);
    ack_end   = scl_fall && in_ack && !prog_busy;
    // One rising edge of the next byte is part of any STOP/START shape
    commit_ok = (state == ST_WDATA) && (bit_cnt <= 4'd1) && !in_ack && buf_any;
    buf_wr    = byte_done && (state == ST_WDATA) && !wr_lock_i;
    prog_start = !prog_busy && stop_det && commit_ok;
    buf_clr   = prog_done ||
                (!prog_busy && (start_det || (stop_det && !commit_ok)));
    arr_we    = prog_commit && buf_rvalid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      mack     <= 1'b0;
      rx_byte  <= '0;
      tx_rest  <= '0;
      ptr      <= '0;
      sel_hi_q <= '0;
      pull_q   <= 1'b0;
    end else if (!prog_busy) begin
      if (start_det) begin
        state   <= ST_SEL;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        pull_q  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        in_ack <= 1'b0;
        pull_q <= 1'b0;
      end else if (scl_rise && state != ST_IDLE) begin
        if (bit_cnt < 4'd8) begin
          rx_byte <= {rx_byte[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else begin
          // During the select ack the slave itself holds the line low
          mack <= ~sda_s;
        end
      end else if (byte_done) begin
        in_ack <= 1'b1;
        unique case (state)
          ST_SEL: begin
            if (sel_ok) begin
              pull_q <= 1'b1;
              if (rx_byte[0]) state <= ST_RDATA;
              else begin
                state    <= ST_ADDR;
                sel_hi_q <= sel_hi_field;
              end
            end else begin
              state  <= ST_IDLE;
              in_ack <= 1'b0;
              pull_q <= 1'b0;
            end
          end
          ST_ADDR: begin
            ptr    <= addr_cat;
            pull_q <= 1'b1;
            state  <= ST_WDATA;
          end
          ST_WDATA: begin
            pull_q <= !wr_lock_i;
            if (!wr_lock_i) ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
          end
          ST_RDATA: begin
            pull_q <= 1'b0;
            ptr    <= ptr + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end else if (ack_end) begin
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        if (state == ST_RDATA && mack) begin
          tx_rest <= rd_q[6:0];
          pull_q  <= ~rd_q[7];
        end else begin
          pull_q <= 1'b0;
          if (state == ST_RDATA) state <= ST_IDLE;
        end
      end else if (scl_fall && state == ST_RDATA && !in_ack &&
                   bit_cnt != 4'd0 && bit_cnt < 4'd8) begin
        pull_q  <= ~tx_rest[6];
        tx_rest <= {tx_rest[5:0], 1'b0};
      end
    end
  end

  assign sda_pull_o = pull_q;

  smem_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk, .rst,
    .clr_i(buf_clr), .wr_i(buf_wr),
    .wr_idx_i(ptr[PW-1:0]), .wr_data_i(rx_byte),
    .rd_idx_i(commit_idx), .rd_data_o(buf_rdata),
    .rd_valid_o(buf_rvalid), .any_o(buf_any)
  );

  smem_prog_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_prog (
    .clk, .rst,
    .start_i(prog_start), .busy_o(prog_busy), .commit_o(prog_commit),
    .idx_o(commit_idx), .done_o(prog_done)
  );

  smem_array #(.DEPTH(MEM_BYTES)) u_array (
    .clk,
    .we_i(arr_we),
    .waddr_i({ptr[AW-1:PW], commit_idx}),
    .wdata_i(buf_rdata),
    .raddr_i(ptr),
    .rdata_o(rd_q)
  );

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull_q) |-> !scl_s); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    prog_busy |-> !pull_q); // R6
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (state == ST_IDLE)); // R6
  AST_LOCK_NACK: assert property (@(posedge clk) disable iff (rst)
    (byte_done && state == ST_WDATA && wr_lock_i) |=> !pull_q); // R5
  AST_SEL_MISS: assert property (@(posedge clk) disable iff (rst)
    (byte_done && state == ST_SEL && !sel_ok) |=> (!pull_q && state == ST_IDLE)); // R1

endmodule

// File: tb/tb_twowire_mem_slave.sv
module tb_twowire_mem_slave;
  localparam int MEMB = 512;
  localparam int BUSY = 300;
  localparam int Q    = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_lock = 1'b0;
  logic [2:0] cs = 3'b110;
  logic pull;
  wire  sda_line = sda_m & ~pull;

  int total = 0, bad = 0;
  logic [7:0] rbuf [0:31];

  always #5 clk = ~clk;

  twowire_mem_slave #(.MEM_BYTES(MEMB), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY),
                      .SYNC_STAGES(2)) dut (
    .clk, .rst, .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(pull),
    .chip_sel_i(cs), .wr_lock_i(wr_lock)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      d = {d[6:0], sda_line}; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  // Select byte: 1010, straps 1,1 in bits 3..2, address bit 8 in bit 1, rw in bit 0
  function automatic logic [7:0] sel_code(input logic [8:0] a, input logic rd);
    return 8'hAC | {6'b0, a[8], rd};
  endfunction

  task automatic wr_txn(input logic [8:0] a, input int n, input logic [7:0] seed,
                        output logic sa, output logic aa, output logic da);
    logic b;
    bus_start();
    send_byte(sel_code(a, 1'b0), sa);
    send_byte(a[7:0], aa);
    da = 1'b1;
    for (int i = 0; i < n; i++) begin
      send_byte(seed + 8'(i), b);
      da = da & b;
    end
    bus_stop();
  endtask

  task automatic write_commit(input logic [8:0] a, input int n, input logic [7:0] seed);
    logic sa, aa, da;
    wr_txn(a, n, seed, sa, aa, da);
    chk("R3", "write select ack", 16'(sa), 16'h1);
    chk("R4", "write data acks", 16'(aa & da), 16'h1);
    tick(BUSY + 100);
  endtask

  task automatic rd_rand(input logic [8:0] a, input int n, output logic ok);
    logic x, y, z;
    bus_start();
    send_byte(sel_code(a, 1'b0), x);
    send_byte(a[7:0], y);
    bus_start();
    send_byte(sel_code(a, 1'b1), z);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
    ok = x & y & z;
  endtask

  task automatic t_reset();
    logic a;
    chk("R11", "pull released after reset", 16'(pull), 16'h0);
    send_byte(8'hAC, a);
    chk("R11", "no answer before START", 16'(a), 16'h0);
  endtask

  task automatic t_select();
    logic a;
    bus_start();
    send_byte(8'hBC, a);
    chk("R1", "wrong type nibble", 16'(a), 16'h0);
    send_byte(8'hAC, a);
    chk("R1", "ignored until next START", 16'(a), 16'h0);
    bus_stop();
    bus_start();
    send_byte(8'hA4, a);
    chk("R1", "strap mismatch", 16'(a), 16'h0);
    bus_stop();
    bus_start();
    send_byte(8'hAC, a);
    chk("R1", "matching select", 16'(a), 16'h1);
    send_byte(8'h00, a);
    chk("R3", "address ack", 16'(a), 16'h1);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic ok;
    write_commit(9'h005, 1, 8'h3C);
    rd_rand(9'h005, 1, ok);
    chk("R8", "random read acks", 16'(ok), 16'h1);
    chk("R8", "random read data", 16'(rbuf[0]), 16'h3C);
  endtask

  task automatic t_page();
    logic ok, a;
    write_commit(9'h020, 9, 8'h40);
    rd_rand(9'h020, 8, ok);
    for (int i = 0; i < 8; i++)
      chk("R9", "sequential page data", 16'(rbuf[i]), 16'(8'h40 + 8'(i)));
    bus_start();
    send_byte(8'hAD, a);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    chk("R9", "current address read", 16'(rbuf[0]), 16'h48);
  endtask

  task automatic t_page_wrap();
    logic ok;
    write_commit(9'h040, 1, 8'h77);
    write_commit(9'h03E, 4, 8'h80);
    rd_rand(9'h030, 2, ok);
    chk("R4", "wrapped byte at 0x30", 16'(rbuf[0]), 16'h82);
    chk("R4", "wrapped byte at 0x31", 16'(rbuf[1]), 16'h83);
    rd_rand(9'h03E, 2, ok);
    chk("R4", "byte at 0x3E", 16'(rbuf[0]), 16'h80);
    chk("R4", "byte at 0x3F", 16'(rbuf[1]), 16'h81);
    rd_rand(9'h040, 1, ok);
    chk("R4", "next page untouched", 16'(rbuf[0]), 16'h77);
  endtask

  task automatic t_overflow();
    logic ok;
    write_commit(9'h050, 17, 8'h10);
    rd_rand(9'h050, 2, ok);
    chk("R4", "17th byte replaces first", 16'(rbuf[0]), 16'h20);
    chk("R4", "second slot kept", 16'(rbuf[1]), 16'h11);
  endtask

  task automatic t_lock();
    logic sa, aa, da, ok;
    wr_lock = 1'b1;
    wr_txn(9'h005, 1, 8'hAA, sa, aa, da);
    chk("R5", "select acked while locked", 16'(sa & aa), 16'h1);
    chk("R5", "data not acked while locked", 16'(da), 16'h0);
    tick(BUSY + 100);
    wr_lock = 1'b0;
    rd_rand(9'h005, 1, ok);
    chk("R5", "locked data not stored", 16'(rbuf[0]), 16'h3C);
  endtask

  task automatic t_busy();
    logic sa, aa, da, a, ok;
    wr_txn(9'h060, 1, 8'h11, sa, aa, da);
    bus_start();
    send_byte(sel_code(9'h060, 1'b1), a);
    chk("R6", "no ack while programming", 16'(a), 16'h0);
    bus_stop();
    tick(BUSY + 100);
    rd_rand(9'h060, 1, ok);
    chk("R6", "data present after cycle", 16'(rbuf[0]), 16'h11);
  endtask

  task automatic t_abort();
    logic a, ok;
    write_commit(9'h070, 2, 8'h22);
    bus_start();
    send_byte(sel_code(9'h070, 1'b0), a);
    send_byte(8'h70, a);
    send_byte(8'h99, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    rd_rand(9'h070, 1, ok);
    chk("R7", "no busy after mid-byte STOP", 16'(ok), 16'h1);
    chk("R7", "mid-byte STOP discards", 16'(rbuf[0]), 16'h22);
    bus_start();
    send_byte(sel_code(9'h071, 1'b0), a);
    send_byte(8'h71, a);
    send_byte(8'h55, a);
    bus_start();
    send_byte(sel_code(9'h071, 1'b1), a);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    rd_rand(9'h071, 1, ok);
    chk("R7", "no busy after repeated START", 16'(ok), 16'h1);
    chk("R7", "repeated START discards", 16'(rbuf[0]), 16'h23);
  endtask

  task automatic t_density();
    logic ok;
    write_commit(9'h1FF, 1, 8'hE1);
    write_commit(9'h000, 1, 8'hE2);
    write_commit(9'h0FF, 1, 8'hD0);
    rd_rand(9'h1FF, 2, ok);
    chk("R2", "high address bit in select", 16'(rbuf[0]), 16'hE1);
    chk("R9", "wrap from last address to 0", 16'(rbuf[1]), 16'hE2);
    rd_rand(9'h0FF, 1, ok);
    chk("R2", "low half distinct", 16'(rbuf[0]), 16'hD0);
    cs = 3'b111;
    rd_rand(9'h1FF, 1, ok);
    chk("R2", "strap bit 0 ignored", 16'(ok), 16'h1);
    chk("R2", "data with strap bit 0 changed", 16'(rbuf[0]), 16'hE1);
    cs = 3'b110;
  endtask

  task automatic t_nack_end();
    logic a;
    bus_start();
    send_byte(8'hAD, a);
    recv_byte(1'b0, rbuf[0]);
    chk("R10", "pull released after nack", 16'(pull), 16'h0);
    recv_byte(1'b0, rbuf[1]);
    chk("R10", "line idle after nack", 16'(rbuf[1]), 16'hFF);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_select();
    t_byte_write();
    t_page();
    t_page_wrap();
    t_overflow();
    t_lock();
    t_busy();
    t_abort();
    t_density();
    t_nack_end();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule